// File: doc/BRIEF.md
# AXI4 Burst Read Master

This block fetches a contiguous region of memory over the read half of an AXI4 port and hands the data to a plain valid-qualified output stream. A client asks for a transfer by giving a start byte address and a length counted in 32-bit words. The block moves the data as 64-bit beats, so one beat carries two words. It splits the request into a chain of incrementing bursts, each at most `MAX_BEATS` beats long (256 by default). Exactly one burst is outstanding at any time.

For each burst, the block drives the read-address channel and holds it until the slave accepts it. Only then does it raise its data-channel ready. It forwards every accepted beat to the output stream, in arrival order. The beat marked last closes the burst. If beats remain, the next burst is planned from the running beat count; otherwise the block pulses a completion flag and returns to idle.

Every beat's response code is inspected. An error response latches a sticky error output, which is cleared only when the next request is accepted. The block rejects malformed requests (zero or odd word counts) on the spot, without touching the bus.

Top module: `axi_burst_reader`

## Requirements
- R1: `req_ready` is high exactly while the block is idle. A request is taken only when `req_valid` and `req_ready` are both high at a clock edge. From the next cycle until `done`, `req_ready` is low, and `req_valid` has no effect.
- R2: A request whose word count is zero, or odd, is refused. `req_reject` is high for the one cycle after the request edge, `req_ready` stays high, and no address is issued on the read-address channel.
- R3: The request produces word count / 2 beats in total. Each burst carries min(`MAX_BEATS`, beats still remaining) beats, and `m_arlen` equals that beat count minus one.
- R4: Each burst address equals the start address plus 8 times the number of beats already received for the request. `m_arburst` is 2'b01 (incrementing) and `m_arsize` is 3'b011 (8 bytes per beat).
- R5: Once `m_arvalid` is high, it stays high with `m_araddr` and `m_arlen` unchanged until the cycle in which `m_arready` is high.
- R6: `m_rready` is low while a burst address is pending. It is high from the cycle after the address handshake, and low again from the cycle after the beat carrying `m_rlast`.
- R7: Each beat accepted on the data channel appears on `out_data` with `out_valid` high in the following cycle, in arrival order.
- R8: No new burst address is presented while a burst's data is still being received. `done` pulses for one cycle, in the cycle after the last beat of the last burst, and `req_ready` is high in that cycle.
- R9: `err` becomes high in the cycle after any beat with response 2'b10 (SLVERR) or 2'b11 (DECERR) and stays high. Responses 2'b00 (OKAY) and 2'b01 (EXOKAY) leave it low. It clears when the next valid request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_addr | input | ADDR_W | Start byte address, 8-byte aligned |
| req_words | input | WORDS_W | Transfer length in 32-bit words |
| req_ready | output | 1 | Idle, able to take a request |
| req_reject | output | 1 | One-cycle pulse for a refused request |
| m_araddr | output | ADDR_W | Burst start address |
| m_arlen | output | 8 | Beats in burst minus one |
| m_arsize | output | 3 | Beat size code |
| m_arburst | output | 2 | Burst type |
| m_arvalid | output | 1 | Address valid |
| m_arready | input | 1 | Address accepted by slave |
| m_rdata | input | DATA_W | Read beat data |
| m_rresp | input | 2 | Read beat response |
| m_rlast | input | 1 | Final beat of burst |
| m_rvalid | input | 1 | Read beat valid |
| m_rready | output | 1 | Master accepts beats |
| out_valid | output | 1 | Output beat valid |
| out_data | output | DATA_W | Output beat data |
| done | output | 1 | Request complete pulse |
| err | output | 1 | Sticky error response flag |

## Verification
The bench targets three kinds of length. The first is exactly one full burst (256 beats). The second is one beat past it (257 beats), where a design off by one would issue a wrong `m_arlen` or drop the trailing single-beat burst. The third is a three-burst chain, where a wrong address step would refetch or skip memory. The slave model stalls the address and data handshakes at random. This exposes a master that drops `m_arvalid` early, raises `m_rready` before its address is taken, or loses beats across gaps. Error responses are placed mid-burst, so a missed error, an error raised on EXOKAY, or a flag that survives into the next request shows up at `err`. Zero and odd lengths, plus a request strobed while busy, catch a master that starts bus traffic it should have refused.

// File: rtl/axi_brd_pkg.sv
package axi_brd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_ADDR = 2'd2,
    ST_DATA = 2'd3
  } brd_state_e;

  localparam int          AXI_LEN_W  = 8;
  localparam logic [1:0]  BURST_INCR = 2'b01;
endpackage

// File: rtl/brd_planner.sv
module brd_planner
  import axi_brd_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int CNT_W      = 16,
  parameter int BEAT_BYTES = 8,
  parameter int MAX_BEATS  = 256
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 load_i,
  input  logic [ADDR_W-1:0]    load_addr_i,
  input  logic [CNT_W-1:0]     load_beats_i,
  input  logic                 beat_i,
  output logic [ADDR_W-1:0]    burst_addr_o,
  output logic [AXI_LEN_W-1:0] burst_len_o,
  output logic                 final_beat_o
);
  localparam int               SHIFT   = $clog2(BEAT_BYTES);
  localparam logic [CNT_W-1:0] MAX_CNT = CNT_W'(MAX_BEATS);

  logic [ADDR_W-1:0] base_q;
  logic [CNT_W-1:0]  taken_q;
  logic [CNT_W-1:0]  left_q;
  logic [CNT_W-1:0]  chunk;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q  <= '0;
      taken_q <= '0;
      left_q  <= '0;
    end else if (load_i) begin
      base_q  <= load_addr_i;
      taken_q <= '0;
      left_q  <= load_beats_i;
    end else if (beat_i) begin
      taken_q <= taken_q + CNT_W'(1);
      if (left_q != '0) left_q <= left_q - CNT_W'(1);
    end
  end

  always_comb begin
    chunk        = (left_q > MAX_CNT) ? MAX_CNT : left_q;
    burst_len_o  = AXI_LEN_W'(chunk - CNT_W'(1));
    burst_addr_o = base_q + (ADDR_W'(taken_q) << SHIFT);
    final_beat_o = (left_q == CNT_W'(1));
  end
endmodule

// File: rtl/brd_ctrl.sv
module brd_ctrl
  import axi_brd_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int WORDS_W = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_valid_i,
  input  logic [WORDS_W-1:0]   req_words_i,
  output logic                 req_ready_o,
  output logic                 req_reject_o,
  output logic                 start_o,
  input  logic [ADDR_W-1:0]    plan_addr_i,
  input  logic [AXI_LEN_W-1:0] plan_len_i,
  input  logic                 final_beat_i,
  output logic                 ar_valid_o,
  output logic [ADDR_W-1:0]    ar_addr_o,
  output logic [AXI_LEN_W-1:0] ar_len_o,
  input  logic                 ar_ready_i,
  input  logic                 r_valid_i,
  input  logic                 r_last_i,
  output logic                 r_ready_o,
  output logic                 done_o
);
  brd_state_e state_q;
  logic       bad_len;

  assign bad_len     = (req_words_i == '0) || req_words_i[0];
  assign req_ready_o = (state_q == ST_IDLE);
  assign start_o     = (state_q == ST_IDLE) && req_valid_i && !bad_len;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= ST_IDLE;
      ar_valid_o   <= 1'b0;
      ar_addr_o    <= '0;
      ar_len_o     <= '0;
      r_ready_o    <= 1'b0;
      done_o       <= 1'b0;
      req_reject_o <= 1'b0;
    end else begin
      done_o       <= 1'b0;
      req_reject_o <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (req_valid_i) begin
            if (bad_len) req_reject_o <= 1'b1;
            else         state_q      <= ST_LOAD;
          end
        end
        ST_LOAD: begin
          ar_valid_o <= 1'b1;
          ar_addr_o  <= plan_addr_i;
          ar_len_o   <= plan_len_i;
          state_q    <= ST_ADDR;
        end
        ST_ADDR: begin
          if (ar_ready_i) begin
            ar_valid_o <= 1'b0;
            r_ready_o  <= 1'b1;
            state_q    <= ST_DATA;
          end
        end
        ST_DATA: begin
          if (r_valid_i && r_last_i) begin
            r_ready_o <= 1'b0;
            if (final_beat_i) begin
              done_o  <= 1'b1;
              state_q <= ST_IDLE;
            end else begin
              state_q <= ST_LOAD;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/brd_sink.sv
module brd_sink #(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear_i,
  input  logic              beat_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [1:0]        resp_i,
  output logic              out_valid_o,
  output logic [DATA_W-1:0] out_data_o,
  output logic              err_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid_o <= 1'b0;
      out_data_o  <= '0;
      err_o       <= 1'b0;
    end else begin
      out_valid_o <= beat_i;
      if (beat_i) out_data_o <= data_i;
      if (clear_i)                  err_o <= 1'b0;
      else if (beat_i && resp_i[1]) err_o <= 1'b1;
    end
  end
endmodule

// File: rtl/axi_burst_reader.sv
module axi_burst_reader
  import axi_brd_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 64,
  parameter int WORDS_W   = 16,
  parameter int MAX_BEATS = 256
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [WORDS_W-1:0] req_words,
  output logic               req_ready,
  output logic               req_reject,
  output logic [ADDR_W-1:0]  m_araddr,
  output logic [7:0]         m_arlen,
  output logic [2:0]         m_arsize,
  output logic [1:0]         m_arburst,
  output logic               m_arvalid,
  input  logic               m_arready,
  input  logic [DATA_W-1:0]  m_rdata,
  input  logic [1:0]         m_rresp,
  input  logic               m_rlast,
  input  logic               m_rvalid,
  output logic               m_rready,
  output logic               out_valid,
  output logic [DATA_W-1:0]  out_data,
  output logic               done,
  output logic               err
);
  localparam int BEAT_BYTES = DATA_W / 8;

  logic                 start;
  logic                 beat;
  logic [ADDR_W-1:0]    plan_addr;
  logic [AXI_LEN_W-1:0] plan_len;
  logic                 final_beat;
  logic [WORDS_W-1:0]   req_beats;

  assign beat      = m_rvalid && m_rready;
  assign req_beats = req_words >> 1;
  assign m_arsize  = 3'($clog2(BEAT_BYTES));
  assign m_arburst = BURST_INCR;

  brd_planner #(
    .ADDR_W(ADDR_W), .CNT_W(WORDS_W), .BEAT_BYTES(BEAT_BYTES), .MAX_BEATS(MAX_BEATS)
  ) u_plan (
    .clk(clk), .rst(rst), .load_i(start), .load_addr_i(req_addr),
    .load_beats_i(req_beats), .beat_i(beat), .burst_addr_o(plan_addr),
    .burst_len_o(plan_len), .final_beat_o(final_beat)
  );

  brd_ctrl #(.ADDR_W(ADDR_W), .WORDS_W(WORDS_W)) u_ctrl (
    .clk(clk), .rst(rst), .req_valid_i(req_valid), .req_words_i(req_words),
    .req_ready_o(req_ready), .req_reject_o(req_reject), .start_o(start),
    .plan_addr_i(plan_addr), .plan_len_i(plan_len), .final_beat_i(final_beat),
    .ar_valid_o(m_arvalid), .ar_addr_o(m_araddr), .ar_len_o(m_arlen),
    .ar_ready_i(m_arready), .r_valid_i(m_rvalid), .r_last_i(m_rlast),
    .r_ready_o(m_rready), .done_o(done)
  );

  brd_sink #(.DATA_W(DATA_W)) u_sink (
    .clk(clk), .rst(rst), .clear_i(start), .beat_i(beat), .data_i(m_rdata),
    .resp_i(m_rresp), .out_valid_o(out_valid), .out_data_o(out_data), .err_o(err)
  );
endmodule

// File: rtl/axi_burst_reader_chk.sv
module axi_burst_reader_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              req_ready,
  input logic              req_reject,
  input logic [ADDR_W-1:0] m_araddr,
  input logic [7:0]        m_arlen,
  input logic              m_arvalid,
  input logic              m_arready,
  input logic [1:0]        m_rresp,
  input logic              m_rlast,
  input logic              m_rvalid,
  input logic              m_rready,
  input logic              out_valid,
  input logic              done,
  input logic              err
);
  // R5
  ar_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (m_arvalid && !m_arready) |=> (m_arvalid && $stable(m_araddr) && $stable(m_arlen)));

  // R6
  rready_gate_chk: assert property (@(posedge clk) disable iff (rst)
    m_arvalid |-> !m_rready);

  // R7
  stream_src_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(m_rvalid && m_rready));

  // R9
  err_set_chk: assert property (@(posedge clk) disable iff (rst)
    (m_rvalid && m_rready && m_rresp[1]) |=> err);

  // R2
  reject_idle_chk: assert property (@(posedge clk) disable iff (rst)
    req_reject |-> (req_ready && !m_arvalid));

  // R8
  done_after_last_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> ($past(m_rvalid && m_rready && m_rlast) && req_ready));
endmodule

bind axi_burst_reader axi_burst_reader_chk #(.ADDR_W(ADDR_W)) u_brd_chk (
  .clk(clk), .rst(rst), .req_ready(req_ready), .req_reject(req_reject),
  .m_araddr(m_araddr), .m_arlen(m_arlen), .m_arvalid(m_arvalid),
  .m_arready(m_arready), .m_rresp(m_rresp), .m_rlast(m_rlast),
  .m_rvalid(m_rvalid), .m_rready(m_rready), .out_valid(out_valid),
  .done(done), .err(err)
);

// File: tb/test_axi_burst_reader.sv
`timescale 1ns/1ps
module test_axi_burst_reader;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic [15:0] req_words = '0;
  logic        req_ready, req_reject;
  logic [31:0] m_araddr;
  logic [7:0]  m_arlen;
  logic [2:0]  m_arsize;
  logic [1:0]  m_arburst;
  logic        m_arvalid;
  logic        m_arready = 1'b0;
  logic [63:0] m_rdata = '0;
  logic [1:0]  m_rresp = '0;
  logic        m_rlast = 1'b0;
  logic        m_rvalid = 1'b0;
  logic        m_rready, out_valid, done, err;
  logic [63:0] out_data;

  always #10 clk = ~clk;

  axi_burst_reader i_axi_burst_reader (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_words(req_words), .req_ready(req_ready), .req_reject(req_reject),
    .m_araddr(m_araddr), .m_arlen(m_arlen), .m_arsize(m_arsize),
    .m_arburst(m_arburst), .m_arvalid(m_arvalid), .m_arready(m_arready),
    .m_rdata(m_rdata), .m_rresp(m_rresp), .m_rlast(m_rlast),
    .m_rvalid(m_rvalid), .m_rready(m_rready), .out_valid(out_valid),
    .out_data(out_data), .done(done), .err(err)
  );

  int          checks = 0;
  int          failures = 0;
  bit          finished = 1'b0;
  logic [31:0] exp_base = '0;
  int          exp_beats = 0;
  int          ar_seen = 0;
  int          ar_count = 0;
  int          mon_idx = 0;
  logic [31:0] err_addr = 32'hFFFF_FFF0;
  logic [1:0]  err_code = 2'b10;
  logic [1:0]  ok_code = 2'b00;

  function automatic logic [63:0] mem_word(input logic [31:0] a);
    return {a ^ 32'hC3A5_0000, a + 32'h1};
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // slave model
  initial begin
    int          gap;
    logic [31:0] cap_addr;
    logic [7:0]  cap_len;
    int          rem;
    bit          quiet;
    @(negedge clk);
    while (rst) @(negedge clk);
    forever begin
      @(negedge clk);
      if (m_arvalid) begin
        gap = $urandom_range(0, 2);
        repeat (gap) begin
          chk(m_rready == 1'b0, "R6", "rready during address wait", 64'(m_rready), 64'd0);
          @(negedge clk);
        end
        cap_addr = m_araddr;
        cap_len  = m_arlen;
        rem = exp_beats - ar_seen;
        if (rem > 256) rem = 256;
        chk(m_rready == 1'b0, "R6", "rready before AR handshake", 64'(m_rready), 64'd0);
        chk(cap_len == 8'(rem - 1), "R3", "arlen", 64'(cap_len), 64'(rem - 1));
        chk(cap_addr == exp_base + 32'(ar_seen * 8), "R4", "araddr",
            64'(cap_addr), 64'(exp_base + 32'(ar_seen * 8)));
        chk(m_arsize == 3'b011 && m_arburst == 2'b01, "R4", "arsize/arburst",
            64'({m_arsize, m_arburst}), 64'({3'b011, 2'b01}));
        m_arready = 1'b1;
        @(negedge clk);
        m_arready = 1'b0;
        ar_count++;
        chk(m_arvalid == 1'b0 && m_rready == 1'b1, "R6", "after AR handshake",
            64'({m_arvalid, m_rready}), 64'b01);
        quiet = 1'b1;
        for (int i = 0; i <= int'(cap_len); i++) begin
          repeat ($urandom_range(0, 2)) begin
            if (m_arvalid) quiet = 1'b0;
            @(negedge clk);
          end
          m_rvalid = 1'b1;
          m_rdata  = mem_word(cap_addr + 32'(i * 8));
          m_rresp  = ((cap_addr + 32'(i * 8)) == err_addr) ? err_code : ok_code;
          m_rlast  = (i == int'(cap_len));
          while (!m_rready) @(negedge clk);
          if (m_arvalid) quiet = 1'b0;
          @(negedge clk);
          m_rvalid = 1'b0;
          m_rlast  = 1'b0;
        end
        ar_seen += int'(cap_len) + 1;
        chk(quiet, "R8", "no AR while burst data open", 64'(quiet), 64'd1);
        chk(m_rready == 1'b0, "R6", "rready after rlast", 64'(m_rready), 64'd0);
      end
    end
  end

  // output monitor
  initial begin
    forever begin
      @(negedge clk);
      if (out_valid) begin
        chk(out_data == mem_word(exp_base + 32'(mon_idx * 8)), "R7", "out_data",
            out_data, mem_word(exp_base + 32'(mon_idx * 8)));
        mon_idx++;
      end
    end
  end

  task automatic do_req(input logic [31:0] addr, input logic [15:0] words,
                        input bit exp_err, input bit poke);
    int arc;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1", "ready before request", 64'(req_ready), 64'd1);
    req_valid = 1'b1;
    req_addr  = addr;
    req_words = words;
    if (words != 0 && !words[0]) begin
      exp_base  = addr;
      exp_beats = int'(words) / 2;
      ar_seen   = 0;
      mon_idx   = 0;
    end
    arc = ar_count;
    @(negedge clk);
    req_valid = 1'b0;
    if (words == 0 || words[0]) begin
      chk(req_reject == 1'b1, "R2", "reject pulse", 64'(req_reject), 64'd1);
      chk(req_ready == 1'b1, "R2", "ready after reject", 64'(req_ready), 64'd1);
      repeat (6) @(negedge clk);
      chk(req_reject == 1'b0, "R2", "reject is one cycle", 64'(req_reject), 64'd0);
      chk(ar_count == arc && !m_arvalid, "R2", "no AR traffic", 64'(ar_count - arc), 64'd0);
    end else begin
      chk(req_reject == 1'b0, "R2", "valid request not rejected", 64'(req_reject), 64'd0);
      chk(req_ready == 1'b0, "R1", "busy after accept", 64'(req_ready), 64'd0);
      chk(err == 1'b0, "R9", "err cleared on accept", 64'(err), 64'd0);
      if (poke) begin
        repeat (3) @(negedge clk);
        req_valid = 1'b1;
        req_words = 16'd3;
        req_addr  = 32'h000D_EAD0;
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_reject == 1'b0 && req_ready == 1'b0, "R1", "request ignored while busy",
            64'({req_reject, req_ready}), 64'd0);
      end
      while (!done) @(negedge clk);
      #1;
      chk(req_ready == 1'b1, "R8", "ready with done", 64'(req_ready), 64'd1);
      chk(mon_idx == exp_beats, "R3", "beats delivered", 64'(mon_idx), 64'(exp_beats));
      chk(ar_seen == exp_beats, "R3", "beats requested", 64'(ar_seen), 64'(exp_beats));
      chk(err == exp_err, "R9", "err after request", 64'(err), 64'(exp_err));
      @(negedge clk);
      chk(done == 1'b0, "R8", "done is one cycle", 64'(done), 64'd0);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready && !m_arvalid && !m_rready && !out_valid && !done && !err,
        "R1", "reset state",
        64'({req_ready, m_arvalid, m_rready, out_valid, done, err}), 64'b100000);
    do_req(32'h0000_1000, 16'd0, 1'b0, 1'b0);
    do_req(32'h0000_1000, 16'd7, 1'b0, 1'b0);
    do_req(32'h0000_1000, 16'd2, 1'b0, 1'b0);
    do_req(32'h0002_0000, 16'd512, 1'b0, 1'b0);
    do_req(32'h0004_0000, 16'd514, 1'b0, 1'b1);
    do_req(32'h0008_0000, 16'd1030, 1'b0, 1'b0);
    for (int k = 0; k < 8; k++) begin
      do_req(32'h0010_0000 + {13'd0, 16'($urandom_range(1, 16'h7FFF)), 3'b000},
             16'(2 * $urandom_range(1, 40)), 1'b0, 1'b0);
    end
    err_addr = 32'h0000_3018; err_code = 2'b10;
    do_req(32'h0000_3000, 16'd20, 1'b1, 1'b0);
    err_addr = 32'hFFFF_FFF0;
    do_req(32'h0000_5000, 16'd6, 1'b0, 1'b0);
    err_addr = 32'h0000_6008; err_code = 2'b11;
    do_req(32'h0000_6000, 16'd4, 1'b1, 1'b0);
    err_addr = 32'hFFFF_FFF0; ok_code = 2'b01;
    do_req(32'h0000_7000, 16'd10, 1'b0, 1'b0);
    ok_code = 2'b00;
    do_req(32'h0000_8000, 16'd9, 1'b0, 1'b0);
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog R8 run did not complete: actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule